// File: doc/BRIEF.md
# Instruction Namespace Page Stack

This controller sits beside an instruction decoder and tracks which alternate opcode page, if any, is in force. The decoder hands it three kinds of commands: push a page, pop one level, or clear back to the base instruction set. It also receives a retire strobe and a taken-branch flag. Up to four page selections can be stacked. Each level holds a 3-bit subpage number and a 4-bit activation length, counted in retired instructions. The length value 15 marks a level as permanent.

Only the top level counts down. When its count runs out, that level drops off by itself and the level beneath it becomes active again. A taken branch ends every finite activation and keeps the permanent levels. The whole stack packs into one 32-bit CSR word. Software can read and write that word to save and restore the namespace state around calls.

Top module: `ns_page_stack`

## Requirements
- R1: After synchronous reset, the stack is empty. The CSR reads 0, `ns_default_o` is 1, `ns_page_o` is 0 and `overflow_o` is 0.
- R2: A push (`cmd_op_i` = 1) with a non-zero length stores {page, length} in the lowest free slot and raises the depth by one. From the next cycle the page appears on `ns_page_o`. A push with length 0 has no effect.
- R3: A push at depth 4 leaves the stack unchanged and sets `overflow_o`. That flag stays set until reset.
- R4: Each retire decrements the top level's length, unless that length is 15. A top level whose length would reach 0 is removed, and the level below it becomes active.
- R5: A taken branch removes every level whose length is not 15. The permanent levels stay, packed downward in their original order.
- R6: A pop (`cmd_op_i` = 2) removes the top level and exposes the one beneath it. A pop at depth 0 has no effect.
- R7: A clear (`cmd_op_i` = 3) empties the stack, so the base instruction set is in force.
- R8: When several events fall in one cycle, they apply in this order: the retire countdown first, then the branch flush, then the command.
- R9: The CSR layout is as follows:
  - Slot i occupies bits [7i+6:7i]: the page in [7i+6:7i+4] and the length in [7i+3:7i].
  - The depth is in bits [30:28].
  - Bit 31 reads 0.
  - Slots at or above the depth read 0.
- R10: A CSR write replaces the whole state, and all other inputs in that cycle are ignored. A depth above 4 is clamped to 4, and slots at or above the written depth are cleared.
- R11: At depth 0, `ns_default_o` is 1 and `ns_page_o` is 0. Otherwise, `ns_default_o` is 0 and `ns_page_o` shows the top level's page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| branch_taken_i | input | 1 | A taken branch; ends finite activations |
| cmd_op_i | input | 2 | 0 none, 1 push, 2 pop, 3 clear |
| cmd_page_i | input | 3 | Subpage number for a push |
| cmd_len_i | input | 4 | Activation length for a push (15 = permanent) |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Packed stack state |
| ns_default_o | output | 1 | Base instruction set in force |
| ns_page_o | output | 3 | Active subpage number |
| overflow_o | output | 1 | Sticky push-overflow flag |

## Verification
The delicate interaction is a retire that exhausts the top level's countdown in the same cycle as a push or a pop. The retire's automatic removal happens first, so a pop in that cycle takes away a second level, and a push lands in the slot just freed. The bench provokes these collisions directly, and also pairs a branch with a push and a branch with a retire. A reference model of queues, stepped in the stated order, judges every cycle. A long random stretch then mixes all of the events, including occasional CSR writes.

// File: rtl/ns_stack_pkg.sv
package ns_stack_pkg;

    localparam int unsigned NS_DEPTH  = 4;
    localparam int unsigned NS_PAGE_W = 3;
    localparam int unsigned NS_LEN_W  = 4;
    localparam int unsigned NS_CSR_W  = 32;

    localparam int unsigned NS_CNT_W = $clog2(NS_DEPTH + 1);
    localparam int unsigned NS_IDX_W = $clog2(NS_DEPTH);

    localparam logic [NS_LEN_W-1:0] NS_LEN_PERM = '1;
    localparam logic [NS_CNT_W-1:0] NS_FULL     = NS_CNT_W'(NS_DEPTH);

    typedef struct packed {
        logic [NS_PAGE_W-1:0] page;
        logic [NS_LEN_W-1:0]  len;
    } ns_entry_t;

    typedef struct packed {
        logic [NS_CNT_W-1:0]          depth;
        ns_entry_t [NS_DEPTH-1:0]     ent;
    } ns_state_t;

    localparam int unsigned NS_STATE_W = $bits(ns_state_t);

    typedef enum logic [1:0] {
        NS_OP_NONE  = 2'd0,
        NS_OP_PUSH  = 2'd1,
        NS_OP_POP   = 2'd2,
        NS_OP_CLEAR = 2'd3
    } ns_op_e;

    // Entry at the top of the stack, or all zero when empty.
    function automatic ns_entry_t ns_top(input ns_state_t s);
        ns_entry_t e;
        e = '0;
        if (s.depth != '0)
            e = s.ent[NS_IDX_W'(s.depth - 1'b1)];
        return e;
    endfunction

    // Clamp the depth and clear every slot at or above it.
    function automatic ns_state_t ns_scrub(input ns_state_t s_in);
        ns_state_t s;
        s = s_in;
        if (s.depth > NS_FULL)
            s.depth = NS_FULL;
        for (int i = 0; i < NS_DEPTH; i++) begin
            if (NS_CNT_W'(i) >= s.depth)
                s.ent[i] = '0;
        end
        return s;
    endfunction

    function automatic logic [NS_CSR_W-1:0] ns_pack(input ns_state_t s);
        return {(NS_CSR_W - NS_STATE_W)'(0), s};
    endfunction

    function automatic ns_state_t ns_unpack(input logic [NS_CSR_W-1:0] w);
        ns_state_t s;
        s = ns_state_t'(w[NS_STATE_W-1:0]);
        return ns_scrub(s);
    endfunction

endpackage

// File: rtl/ns_retire_step.sv
module ns_retire_step
    import ns_stack_pkg::*;
(
    input  ns_state_t st_i,
    input  logic      retire_i,
    output ns_state_t st_o
);
    logic [NS_IDX_W-1:0] top_idx;
    ns_entry_t           top_ent;

    always_comb begin
        st_o    = st_i;
        top_idx = NS_IDX_W'(st_i.depth - 1'b1);
        top_ent = st_i.ent[top_idx];
        if (retire_i && st_i.depth != '0 && top_ent.len != NS_LEN_PERM) begin
            if (top_ent.len <= NS_LEN_W'(1)) begin
                // countdown exhausted: level drops off
                st_o.ent[top_idx] = '0;
                st_o.depth        = st_i.depth - 1'b1;
            end else begin
                st_o.ent[top_idx].len = top_ent.len - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ns_branch_flush.sv
module ns_branch_flush
    import ns_stack_pkg::*;
(
    input  ns_state_t st_i,
    input  logic      flush_i,
    output ns_state_t st_o
);
    logic [NS_DEPTH-1:0] keep;
    logic [NS_CNT_W-1:0] wr_pos;
    ns_state_t           kept;

    for (genvar g = 0; g < NS_DEPTH; g++) begin : g_keep
        assign keep[g] = (NS_CNT_W'(g) < st_i.depth) &&
                         (st_i.ent[g].len == NS_LEN_PERM);
    end

    // Pack the permanent levels downward, preserving their order.
    always_comb begin
        kept   = '0;
        wr_pos = '0;
        for (int i = 0; i < NS_DEPTH; i++) begin
            if (keep[i]) begin
                kept.ent[wr_pos[NS_IDX_W-1:0]] = st_i.ent[i];
                wr_pos = wr_pos + 1'b1;
            end
        end
        kept.depth = wr_pos;
        st_o = flush_i ? kept : st_i;
    end
endmodule

// File: rtl/ns_cmd_apply.sv
module ns_cmd_apply
    import ns_stack_pkg::*;
(
    input  ns_state_t            st_i,
    input  ns_op_e               op_i,
    input  logic [NS_PAGE_W-1:0] page_i,
    input  logic [NS_LEN_W-1:0]  len_i,
    output ns_state_t            st_o,
    output logic                 overflow_o
);
    logic [NS_IDX_W-1:0] free_idx;
    logic [NS_IDX_W-1:0] top_idx;

    always_comb begin
        st_o       = st_i;
        overflow_o = 1'b0;
        free_idx   = st_i.depth[NS_IDX_W-1:0];
        top_idx    = NS_IDX_W'(st_i.depth - 1'b1);
        unique case (op_i)
            NS_OP_PUSH: begin
                if (len_i != '0) begin
                    if (st_i.depth == NS_FULL) begin
                        overflow_o = 1'b1;
                    end else begin
                        st_o.ent[free_idx].page = page_i;
                        st_o.ent[free_idx].len  = len_i;
                        st_o.depth              = st_i.depth + 1'b1;
                    end
                end
            end
            NS_OP_POP: begin
                if (st_i.depth != '0) begin
                    st_o.ent[top_idx] = '0;
                    st_o.depth        = st_i.depth - 1'b1;
                end
            end
            NS_OP_CLEAR: st_o = '0;
            default: ;
        endcase
    end
endmodule

// File: rtl/ns_page_stack.sv
module ns_page_stack
    import ns_stack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 retire_i,
    input  logic                 branch_taken_i,
    input  logic [1:0]           cmd_op_i,
    input  logic [NS_PAGE_W-1:0] cmd_page_i,
    input  logic [NS_LEN_W-1:0]  cmd_len_i,
    input  logic                 csr_we_i,
    input  logic [NS_CSR_W-1:0]  csr_wdata_i,
    output logic [NS_CSR_W-1:0]  csr_rdata_o,
    output logic                 ns_default_o,
    output logic [NS_PAGE_W-1:0] ns_page_o,
    output logic                 overflow_o
);
    ns_state_t st_q, st_ret, st_br, st_cmd, st_d;
    ns_entry_t top_ent;
    logic      ovf_pulse;
    logic      ovf_q;

    // Same-cycle order: countdown, then branch flush, then command.
    ns_retire_step u_retire (
        .st_i     (st_q),
        .retire_i (retire_i),
        .st_o     (st_ret)
    );

    ns_branch_flush u_flush (
        .st_i    (st_ret),
        .flush_i (branch_taken_i),
        .st_o    (st_br)
    );

    ns_cmd_apply u_cmd (
        .st_i       (st_br),
        .op_i       (ns_op_e'(cmd_op_i)),
        .page_i     (cmd_page_i),
        .len_i      (cmd_len_i),
        .st_o       (st_cmd),
        .overflow_o (ovf_pulse)
    );

    always_comb begin
        st_d = csr_we_i ? ns_unpack(csr_wdata_i) : st_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ovf_pulse && !csr_we_i)
                ovf_q <= 1'b1;
        end
    end

    assign top_ent      = ns_top(st_q);
    assign ns_default_o = (st_q.depth == '0);
    assign ns_page_o    = top_ent.page;
    assign csr_rdata_o  = ns_pack(st_q);
    assign overflow_o   = ovf_q;
endmodule

// File: rtl/ns_page_stack_chk.sv
module ns_page_stack_chk
    import ns_stack_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 branch_taken_i,
    input logic [1:0]           cmd_op_i,
    input logic                 csr_we_i,
    input logic [NS_CSR_W-1:0]  csr_rdata_o,
    input logic                 ns_default_o,
    input logic [NS_PAGE_W-1:0] ns_page_o,
    input logic                 overflow_o
);
    ns_state_t rd_st;
    ns_entry_t rd_top;
    logic      rd_all_perm;

    always_comb begin
        rd_st       = ns_state_t'(csr_rdata_o[NS_STATE_W-1:0]);
        rd_top      = ns_top(rd_st);
        rd_all_perm = 1'b1;
        for (int i = 0; i < NS_DEPTH; i++) begin
            if (NS_CNT_W'(i) < rd_st.depth && rd_st.ent[i].len != NS_LEN_PERM)
                rd_all_perm = 1'b0;
        end
    end

    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    a_r4_perm_holds: assert property (@(posedge clk) disable iff (rst)
        (!csr_we_i && cmd_op_i == NS_OP_NONE && !branch_taken_i &&
         rd_st.depth != '0 && rd_top.len == NS_LEN_PERM) |=> $stable(csr_rdata_o));

    a_r5_flush_finite: assert property (@(posedge clk) disable iff (rst)
        (branch_taken_i && !csr_we_i && cmd_op_i == NS_OP_NONE) |=> rd_all_perm);

    a_r6_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (!csr_we_i && rd_st.depth == '0 && cmd_op_i == NS_OP_POP) |=> (csr_rdata_o == '0));

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (!csr_we_i && cmd_op_i == NS_OP_CLEAR) |=> ns_default_o);

    a_r9_msb_zero: assert property (@(posedge clk) disable iff (rst)
        !csr_rdata_o[NS_CSR_W-1]);

    a_r10_depth_cap: assert property (@(posedge clk) disable iff (rst)
        rd_st.depth <= NS_FULL);

    a_r11_default_page: assert property (@(posedge clk) disable iff (rst)
        ns_default_o |-> (ns_page_o == '0 && rd_st.depth == '0));
endmodule

bind ns_page_stack ns_page_stack_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .branch_taken_i (branch_taken_i),
    .cmd_op_i       (cmd_op_i),
    .csr_we_i       (csr_we_i),
    .csr_rdata_o    (csr_rdata_o),
    .ns_default_o   (ns_default_o),
    .ns_page_o      (ns_page_o),
    .overflow_o     (overflow_o)
);

// File: tb/ns_page_stack_bench.sv
module ns_page_stack_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        retire_i, branch_taken_i, csr_we_i;
    logic [1:0]  cmd_op_i;
    logic [2:0]  cmd_page_i;
    logic [3:0]  cmd_len_i;
    logic [31:0] csr_wdata_i, csr_rdata_o;
    logic        ns_default_o, overflow_o;
    logic [2:0]  ns_page_o;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    int  mp[$];
    int  ml[$];
    bit  movf;

    always #10 clk = ~clk;

    ns_page_stack u_ns_page_stack (
        .clk(clk), .rst(rst), .retire_i(retire_i), .branch_taken_i(branch_taken_i),
        .cmd_op_i(cmd_op_i), .cmd_page_i(cmd_page_i), .cmd_len_i(cmd_len_i),
        .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .ns_default_o(ns_default_o), .ns_page_o(ns_page_o), .overflow_o(overflow_o)
    );

    function automatic logic [31:0] model_csr();
        logic [31:0] v = '0;
        for (int i = 0; i < mp.size(); i++)
            v |= 32'((mp[i] << 4) | ml[i]) << (7 * i);
        v |= 32'(mp.size()) << 28;
        return v;
    endfunction

    task automatic model_step(bit ret, bit br, int op, int pg, int ln, bit we, logic [31:0] wd);
        int d;
        int tp[$];
        int tl[$];
        if (we) begin
            d = int'(wd[30:28]);
            if (d > 4) d = 4;
            mp.delete(); ml.delete();
            for (int i = 0; i < d; i++) begin
                mp.push_back(int'((wd >> (7 * i + 4)) & 32'h7));
                ml.push_back(int'((wd >> (7 * i)) & 32'hF));
            end
            return;
        end
        if (ret && ml.size() > 0 && ml[$] != 15) begin
            if (ml[$] <= 1) begin
                void'(mp.pop_back()); void'(ml.pop_back());
            end else begin
                ml[ml.size() - 1] = ml[$] - 1;
            end
        end
        if (br) begin
            for (int i = 0; i < ml.size(); i++)
                if (ml[i] == 15) begin tp.push_back(mp[i]); tl.push_back(ml[i]); end
            mp = tp; ml = tl;
        end
        case (op)
            1: if (ln != 0) begin
                   if (mp.size() == 4) movf = 1'b1;
                   else begin mp.push_back(pg); ml.push_back(ln); end
               end
            2: if (mp.size() > 0) begin void'(mp.pop_back()); void'(ml.pop_back()); end
            3: begin mp.delete(); ml.delete(); end
            default: ;
        endcase
    endtask

    task automatic compare(string tag);
        logic [31:0] ec;
        logic        ed;
        logic [2:0]  ep;
        ec = model_csr();
        ed = (mp.size() == 0);
        ep = ed ? 3'd0 : 3'(mp[$]);
        n_tests++;
        if (csr_rdata_o !== ec || ns_default_o !== ed || ns_page_o !== ep || overflow_o !== movf) begin
            n_fail++;
            $display("FAIL %s: csr=%h def=%b page=%0d ovf=%b expected csr=%h def=%b page=%0d ovf=%b",
                     tag, csr_rdata_o, ns_default_o, ns_page_o, overflow_o, ec, ed, ep, movf);
        end
    endtask

    task automatic check_word(string tag, logic [31:0] exp);
        n_tests++;
        if (csr_rdata_o !== exp) begin
            n_fail++;
            $display("FAIL %s: csr=%h expected %h", tag, csr_rdata_o, exp);
        end
    endtask

    // Called at a falling edge; drives, steps one clock, compares at the next falling edge.
    task automatic cyc(bit ret, bit br, int op, int pg, int ln, bit we, logic [31:0] wd, string tag);
        retire_i = ret; branch_taken_i = br; cmd_op_i = 2'(op);
        cmd_page_i = 3'(pg); cmd_len_i = 4'(ln); csr_we_i = we; csr_wdata_i = wd;
        @(posedge clk);
        model_step(ret, br, op, pg, ln, we, wd);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic push(int pg, int ln, string tag); cyc(0, 0, 1, pg, ln, 0, 0, tag); endtask
    task automatic pop(string tag);                  cyc(0, 0, 2, 0, 0, 0, 0, tag); endtask
    task automatic clr(string tag);                  cyc(0, 0, 3, 0, 0, 0, 0, tag); endtask
    task automatic ret1(string tag);                 cyc(1, 0, 0, 0, 0, 0, 0, tag); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; retire_i = 0; branch_taken_i = 0; cmd_op_i = 0;
        cmd_page_i = 0; cmd_len_i = 0; csr_we_i = 0; csr_wdata_i = 0; movf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1 reset state");
        check_word("R1 reset csr", 32'h0);

        // R2 push and exact packing (R9)
        push(5, 3, "R2 push");
        check_word("R9 packing", 32'h1000_0053);
        push(6, 0, "R2 zero length ignored");
        // R4 countdown to automatic removal
        ret1("R4 count 2"); ret1("R4 count 1"); ret1("R4 expire");
        ret1("R6 retire on empty");
        // R4 permanent level
        push(2, 15, "R4 perm push");
        for (int i = 0; i < 5; i++) ret1("R4 perm holds");
        // R3 overflow
        push(3, 4, "R2 push 2"); push(4, 9, "R2 push 3"); push(7, 15, "R2 push 4");
        check_word("R9 four slots", {1'b0, 3'd4, 3'd7, 4'd15, 3'd4, 4'd9, 3'd3, 4'd4, 3'd2, 4'd15});
        push(1, 2, "R3 full push");
        push(1, 0, "R3 zero length at full");
        // R6 pops
        pop("R6 pop 1"); pop("R6 pop 2"); pop("R6 pop 3"); pop("R6 pop 4");
        pop("R6 pop empty");
        check_word("R11 empty word", 32'h0);
        // R5 branch flush compaction
        push(1, 15, "R5 build"); push(3, 5, "R5 build"); push(4, 15, "R5 build"); push(6, 9, "R5 build");
        cyc(0, 1, 0, 0, 0, 0, 0, "R5 branch flush");
        check_word("R5 kept order", {1'b0, 3'd2, 14'd0, 3'd4, 4'd15, 3'd1, 4'd15});
        // R7 clear
        clr("R7 clear");
        // R8 collisions
        push(2, 1, "R8 setup"); push(5, 1, "R8 setup");
        cyc(1, 0, 2, 0, 0, 0, 0, "R8 expire plus pop");
        push(2, 3, "R8 setup"); push(5, 1, "R8 setup");
        cyc(1, 0, 1, 6, 7, 0, 0, "R8 expire plus push");
        cyc(1, 1, 1, 3, 2, 0, 0, "R8 branch plus push");
        cyc(1, 1, 0, 0, 0, 0, 0, "R8 branch plus retire");
        clr("R7 clear 2");
        // R10 CSR writes
        cyc(0, 0, 0, 0, 0, 1, 32'hF123_4567, "R10 depth clamp");
        cyc(0, 0, 1, 1, 1, 1, 32'hA7FF_FFFF, "R10 write overrides push, slots cleared");
        check_word("R9 bit31 and upper slots", {1'b0, 3'd2, 14'd0, 14'h3FFF});
        cyc(1, 1, 3, 0, 0, 1, 32'h1000_0012, "R10 write overrides all");
        cyc(0, 0, 0, 0, 0, 1, 32'h0, "R11 write empty");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op > 3) op = (op > 6) ? 1 : 0;
            cyc($urandom_range(0, 1), ($urandom_range(0, 7) == 0), op,
                $urandom_range(0, 7), $urandom_range(0, 15),
                ($urandom_range(0, 31) == 0), $urandom(), "R8 random mix");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule